// File: doc/BRIEF.md
# Sized Shift and Rotate Unit

This block shifts or rotates an 8-bit or 16-bit operand and produces the new zero, carry, overflow and negative flags. Seven operations are offered: left shift (logical and arithmetic are the same), logical right shift, arithmetic right shift, plain rotate left and right, and rotate left and right through the carry flag. It sits beside the main arithmetic unit of a small processor core. The core fetches the operand, presents it with a size bit, an operation code and a shift count, and pulses `start`. It then waits for `done` and writes back the result and the flags.

The count comes from one of two sources. One is a 3-bit immediate field that encodes 1 to 8. The other is the low bits of a register value, which may be zero. The unit works one bit position per clock, so the latency follows the count. All outputs are registered and hold their value until the next operation completes.

Top module: `shift_rotate_unit`

## Requirements
- R1: While `rst` is high and after it is released, `result` is 0, all four flags are 0, and `busy` and `done` are 0.
- R2: `start` is accepted when `busy` is low. `busy` is high from the next clock onward. For an effective count of N, `done` is high for exactly one cycle, N+1 clocks after the accepting edge, and `busy` falls in that same cycle.
- R3: With `use_imm`=1 the count is `imm_cnt`, where 001..111 mean 1..7 and 000 means 8. With `use_imm`=0 the count is the low CNT_W bits of `reg_cnt` (0..31 by default), and the higher bits are ignored.
- R4: With `size`=0 only bits 7:0 are shifted, bits 15:8 of `result` equal those of `operand`, and bit 7 is the sign for the flags. With `size`=1 all 16 bits take part and bit 15 is the sign.
- R5: Op code 0 (left shift) fills with zeros, and carry takes the last bit shifted out of the sign position. Overflow is 1 if the sign bit changed after any single step.
- R6: Op code 1 (logical right shift) fills with zeros, and carry takes the last bit shifted out of bit 0.
- R7: Op code 2 (arithmetic right shift) copies the sign bit into the vacated position, and carry takes the last bit out of bit 0.
- R8: Op code 3 (rotate left) and op code 4 (rotate right) move the outgoing bit into the vacated end. Carry takes the last bit moved.
- R9: Op code 5 (rotate left through carry) and op code 6 (rotate right through carry) move the old carry into the vacated bit, and carry takes the outgoing bit. This is a rotation over width+1 bits.
- R10: For op codes 1 to 6 with a nonzero count, overflow is 0.
- R11: Zero is 1 when the active bits of the result are all 0. Negative is the sign bit of the active width.
- R12: An effective count of zero, or op code 7, leaves `result` equal to `operand`, carry equal to `carry_in` and overflow equal to `ovf_in`. Only zero and negative are recomputed.
- R13: A `start` pulse while `busy` is high is ignored and does not change the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken when not busy) |
| size | input | 1 | 0 = 8-bit, 1 = 16-bit |
| op | input | 3 | Operation code 0..6; 7 acts as no shift |
| use_imm | input | 1 | 1 = count from `imm_cnt`, 0 = from `reg_cnt` |
| imm_cnt | input | 3 | Immediate count, 000 means 8 |
| reg_cnt | input | DATA_W | Register-supplied count value |
| operand | input | DATA_W | Value to shift |
| carry_in | input | 1 | Incoming carry flag |
| ovf_in | input | 1 | Incoming overflow flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W | Shifted value |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_n | output | 1 | Negative flag |

## Verification
The bench uses the default parameters: DATA_W=16, BYTE_W=8 and CNT_W=5. With these values, register counts up to 31 are possible. That covers counts past both operand widths, where plain shifts clear to zero and rotates through carry wrap over 9 or 17 positions. A 3-bit immediate reaches its encoded maximum of 8. The 5-bit count field also allows a `reg_cnt` with set upper bits, which shows that those bits are discarded. The per-step overflow accumulation is reachable in byte mode, where the sign sits at bit 7.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  localparam int IMM_W = 3;

  typedef enum logic [2:0] {
    OP_LSL = 3'd0,
    OP_LSR = 3'd1,
    OP_ASR = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4,
    OP_RLC = 3'd5,
    OP_RRC = 3'd6,
    OP_NOP = 3'd7
  } shop_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } shst_e;
endpackage

// File: rtl/shift_count_sel.sv
module shift_count_sel
  import shifter_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm_cnt,
  input  logic [DATA_W-1:0] reg_cnt,
  output logic [CNT_W-1:0]  cnt
);
  // an all-zero immediate field encodes the largest count
  localparam int IMM_MAX = 2 ** IMM_W;

  always_comb begin
    if (use_imm) begin
      if (imm_cnt == '0) cnt = CNT_W'(IMM_MAX);
      else               cnt = CNT_W'(imm_cnt);
    end else begin
      cnt = reg_cnt[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/shift_step.sv
module shift_step
  import shifter_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  shop_e             op,
  input  logic              size,
  input  logic [DATA_W-1:0] val_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] val_o,
  output logic              c_o,
  output logic              sign_chg
);
  // one lane per operand width; size picks the lane
  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int WID = (g == 0) ? BYTE_W : DATA_W;
    logic [WID-1:0]    x, y;
    logic              cy;
    logic [DATA_W-1:0] merged;
    logic              chg;

    always_comb begin
      x  = val_i[WID-1:0];
      y  = x;
      cy = c_i;
      case (op)
        OP_LSL: begin y = {x[WID-2:0], 1'b0};     cy = x[WID-1]; end
        OP_LSR: begin y = {1'b0, x[WID-1:1]};     cy = x[0];     end
        OP_ASR: begin y = {x[WID-1], x[WID-1:1]}; cy = x[0];     end
        OP_ROL: begin y = {x[WID-2:0], x[WID-1]}; cy = x[WID-1]; end
        OP_ROR: begin y = {x[0], x[WID-1:1]};     cy = x[0];     end
        OP_RLC: begin y = {x[WID-2:0], c_i};      cy = x[WID-1]; end
        OP_RRC: begin y = {c_i, x[WID-1:1]};      cy = x[0];     end
        default: begin y = x; cy = c_i; end
      endcase
      merged           = val_i;
      merged[WID-1:0]  = y;
      chg              = (op == OP_LSL) && (y[WID-1] != x[WID-1]);
    end
  end

  always_comb begin
    if (size) begin
      val_o    = g_lane[1].merged;
      c_o      = g_lane[1].cy;
      sign_chg = g_lane[1].chg;
    end else begin
      val_o    = g_lane[0].merged;
      c_o      = g_lane[0].cy;
      sign_chg = g_lane[0].chg;
    end
  end
endmodule

// File: rtl/shift_flags.sv
module shift_flags #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              size,
  input  logic [DATA_W-1:0] val,
  output logic              z,
  output logic              n
);
  always_comb begin
    if (size) begin
      z = (val == '0);
      n = val[DATA_W-1];
    end else begin
      z = (val[BYTE_W-1:0] == '0);
      n = val[BYTE_W-1];
    end
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shifter_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              size,
  input  logic [2:0]        op,
  input  logic              use_imm,
  input  logic [2:0]        imm_cnt,
  input  logic [DATA_W-1:0] reg_cnt,
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  input  logic              ovf_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v,
  output logic              flag_n
);
  localparam int HI_W = DATA_W - BYTE_W;

  shst_e             state;
  shop_e             op_in, op_q;
  logic [CNT_W-1:0]  cnt_sel, cnt_eff, rem;
  logic [DATA_W-1:0] work, step_val;
  logic              carry_q, ovf_q, size_q, nz_q;
  logic              step_c, step_chg, fz, fn;
  logic              done_q, fz_q, fc_q, fv_q, fn_q;
  logic [DATA_W-1:0] result_q;

  assign op_in   = shop_e'(op);
  assign cnt_eff = (op_in == OP_NOP) ? '0 : cnt_sel;

  shift_count_sel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_cnt (
    .use_imm (use_imm),
    .imm_cnt (imm_cnt),
    .reg_cnt (reg_cnt),
    .cnt     (cnt_sel)
  );

  shift_step #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_step (
    .op       (op_q),
    .size     (size_q),
    .val_i    (work),
    .c_i      (carry_q),
    .val_o    (step_val),
    .c_o      (step_c),
    .sign_chg (step_chg)
  );

  shift_flags #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_flags (
    .size (size_q),
    .val  (work),
    .z    (fz),
    .n    (fn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op_q     <= OP_LSL;
      size_q   <= 1'b0;
      rem      <= '0;
      nz_q     <= 1'b0;
      work     <= '0;
      carry_q  <= 1'b0;
      ovf_q    <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
      fz_q     <= 1'b0;
      fc_q     <= 1'b0;
      fv_q     <= 1'b0;
      fn_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            work    <= operand;
            carry_q <= carry_in;
            ovf_q   <= (cnt_eff == '0) ? ovf_in : 1'b0;
            op_q    <= op_in;
            size_q  <= size;
            rem     <= cnt_eff;
            nz_q    <= (cnt_eff != '0);
            state   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (rem != '0) begin
            work    <= step_val;
            carry_q <= step_c;
            ovf_q   <= ovf_q | step_chg;
            rem     <= rem - 1'b1;
          end else begin
            result_q <= work;
            fc_q     <= carry_q;
            fv_q     <= ovf_q;
            fz_q     <= fz;
            fn_q     <= fn;
            done_q   <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state == ST_RUN);
  assign done   = done_q;
  assign result = result_q;
  assign flag_z = fz_q;
  assign flag_c = fc_q;
  assign flag_v = fv_q;
  assign flag_n = fn_q;

  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: an accepted start makes the unit busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R2: the remaining count falls by one per working cycle
  p_rem_dec_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && rem != '0) |=> (rem == $past(rem) - 1'b1));

  // R4: byte operations never disturb the upper bits
  p_upper_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !size_q) |=> (work[DATA_W-1:DATA_W-HI_W] == $past(work[DATA_W-1:DATA_W-HI_W])));

  // R8: a word rotate keeps the number of set bits
  p_rot_ones_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && rem != '0 && size_q && (op_q == OP_ROL || op_q == OP_ROR))
      |=> ($countones(work) == $countones($past(work))));

  // R10: overflow stays clear for everything but a left shift
  p_no_ovf_r10: assert property (@(posedge clk) disable iff (rst)
    (done && nz_q && op_q != OP_LSL) |-> !flag_v);

  // R13: a start while busy does not reload the operation
  p_busy_ignore_r13: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(op_q) && $stable(size_q)));
endmodule

// File: tb/test_shift_rotate_unit.sv
`timescale 1ns/1ps
module test_shift_rotate_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        start, size, use_imm, carry_in, ovf_in;
  logic [2:0]  op, imm_cnt;
  logic [15:0] reg_cnt, operand;
  logic        busy, done, flag_z, flag_c, flag_v, flag_n;
  logic [15:0] result;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  shift_rotate_unit i_shift_rotate_unit (
    .clk(clk), .rst(rst), .start(start), .size(size), .op(op),
    .use_imm(use_imm), .imm_cnt(imm_cnt), .reg_cnt(reg_cnt),
    .operand(operand), .carry_in(carry_in), .ovf_in(ovf_in),
    .busy(busy), .done(done), .result(result),
    .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v), .flag_n(flag_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference built from the requirement text: {result, z, n, c, v}
  function automatic logic [19:0] model(input int opc, input bit sz, input int cnt,
                                        input logic [15:0] a, input bit cin, input bit vin);
    int w = sz ? 16 : 8;
    logic [15:0] mask = sz ? 16'hFFFF : 16'h00FF;
    logic [15:0] v = a & mask;
    logic [15:0] res;
    bit c = cin, ov = 1'b0, msb, nb, z, n, vo;
    if (opc == 7) cnt = 0;
    for (int k = 0; k < cnt; k++) begin
      msb = v[w-1];
      case (opc)
        0: begin c = v[w-1]; v = (v << 1) & mask; if (v[w-1] != msb) ov = 1'b1; end
        1: begin c = v[0]; v = v >> 1; end
        2: begin c = v[0]; v = v >> 1; v[w-1] = msb; end
        3: begin c = v[w-1]; v = ((v << 1) | 16'(msb)) & mask; end
        4: begin nb = v[0]; c = nb; v = v >> 1; v[w-1] = nb; end
        5: begin nb = c; c = v[w-1]; v = ((v << 1) | 16'(nb)) & mask; end
        6: begin nb = c; c = v[0]; v = v >> 1; v[w-1] = nb; end
        default: ;
      endcase
    end
    res = (a & ~mask) | v;
    z   = (v == 16'h0);
    n   = v[w-1];
    vo  = (cnt == 0) ? vin : ov;
    return {res, z, n, c, vo};
  endfunction

  // drive one operation, measure latency, compare against model
  task automatic run_op(input string tag, input int opc, input bit sz, input bit ui,
                        input logic [2:0] imm, input logic [15:0] rc,
                        input logic [15:0] a, input bit cin, input bit vin,
                        input bit poke_busy);
    int cnt, cyc;
    logic [19:0] e;
    cnt = ui ? ((imm == 3'd0) ? 8 : int'(imm)) : int'(rc[4:0]);   // R3
    if (opc == 7) cnt = 0;                                         // R12
    e = model(opc, sz, cnt, a, cin, vin);
    @(negedge clk);
    start = 1'b1; op = 3'(opc); size = sz; use_imm = ui; imm_cnt = imm;
    reg_cnt = rc; operand = a; carry_in = cin; ovf_in = vin;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R2 busy"}, {31'd0, busy}, 32'd1);
    cyc = 1;
    @(negedge clk);
    while (!done && cyc < 100) begin
      if (poke_busy && cyc == 2) begin
        start = 1'b1; op = 3'd1; size = ~sz; operand = ~a; reg_cnt = 16'd1; use_imm = 1'b0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk({tag, " R2 latency"}, 32'(cyc), 32'(cnt + 1));
    chk({tag, " result"}, {16'd0, result}, {16'd0, e[19:4]});
    chk({tag, " flags zncv"}, {28'd0, flag_z, flag_n, flag_c, flag_v}, {28'd0, e[3:0]});
    @(negedge clk);
    chk({tag, " R2 done pulse"}, {30'd0, done, busy}, 32'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; size = 1'b0; op = 3'd0; use_imm = 1'b0; imm_cnt = 3'd0;
    reg_cnt = 16'd0; operand = 16'd0; carry_in = 1'b0; ovf_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {8'd0, result, 2'd0, flag_z, flag_c, flag_v, flag_n, busy, done}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {8'd0, result, 2'd0, flag_z, flag_c, flag_v, flag_n, busy, done}, 32'd0);
  endtask

  task automatic t_lsl();
    run_op("R5 word lsl1", 0, 1'b1, 1'b1, 3'd1, 16'd0, 16'h8001, 1'b0, 1'b0, 1'b0);
    chk("R5 fixed 8001<<1", {16'd0, result, 4'd0, flag_z, flag_n, flag_c, flag_v}, {16'h0002, 8'h03});
    run_op("R5 R4 byte lsl1", 0, 1'b0, 1'b1, 3'd1, 16'd0, 16'hAB40, 1'b0, 1'b0, 1'b0);
    chk("R4 byte upper kept", {16'd0, result, 4'd0, flag_z, flag_n, flag_c, flag_v}, {16'hAB80, 8'h05});
    run_op("R5 R3 imm000 byte", 0, 1'b0, 1'b1, 3'd0, 16'd0, 16'h00FF, 1'b0, 1'b0, 1'b0);
    chk("R3 imm 000 is 8", {16'd0, result, 4'd0, flag_z, flag_n, flag_c, flag_v}, {16'h0000, 8'h0B});
    run_op("R5 word reg20", 0, 1'b1, 1'b0, 3'd0, 16'd20, 16'h1234, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_right();
    run_op("R6 lsr word", 1, 1'b1, 1'b1, 3'd3, 16'd0, 16'hF00D, 1'b0, 1'b1, 1'b0);
    run_op("R6 R11 lsr byte", 1, 1'b0, 1'b0, 3'd0, 16'd9, 16'h55AA, 1'b1, 1'b0, 1'b0);
    run_op("R7 asr word", 2, 1'b1, 1'b1, 3'd5, 16'd0, 16'h8421, 1'b0, 1'b1, 1'b0);
    run_op("R7 asr byte", 2, 1'b0, 1'b1, 3'd2, 16'd0, 16'h0081, 1'b0, 1'b0, 1'b0);
    chk("R10 ovf clear asr", {31'd0, flag_v}, 32'd0);
  endtask

  task automatic t_rotate();
    run_op("R8 rol word", 3, 1'b1, 1'b1, 3'd4, 16'd0, 16'hC003, 1'b0, 1'b0, 1'b0);
    run_op("R8 ror byte", 4, 1'b0, 1'b0, 3'd0, 16'd11, 16'h7E01, 1'b0, 1'b1, 1'b0);
    run_op("R9 rlc byte", 5, 1'b0, 1'b1, 3'd1, 16'd0, 16'h0081, 1'b0, 1'b0, 1'b0);
    chk("R9 fixed rlc 81", {16'd0, result, 4'd0, flag_z, flag_n, flag_c, flag_v}, {16'h0002, 8'h02});
    run_op("R9 rrc word", 6, 1'b1, 1'b1, 3'd1, 16'd0, 16'h0001, 1'b1, 1'b0, 1'b0);
    chk("R9 fixed rrc 0001", {16'd0, result, 4'd0, flag_z, flag_n, flag_c, flag_v}, {16'h8000, 8'h06});
    run_op("R9 rlc word wrap17", 5, 1'b1, 1'b0, 3'd0, 16'd17, 16'hBEEF, 1'b1, 1'b0, 1'b0);
    chk("R9 wrap17 identity", {16'd0, result, 7'd0, flag_c}, {16'hBEEF, 8'h01});
  endtask

  task automatic t_zero();
    run_op("R12 reg count 0", 0, 1'b1, 1'b0, 3'd0, 16'hFFE0, 16'h0000, 1'b1, 1'b1, 1'b0);
    chk("R12 R3 zero keeps c v", {16'd0, result, 4'd0, flag_z, flag_n, flag_c, flag_v}, {16'h0000, 8'h0B});
    run_op("R12 op7", 7, 1'b0, 1'b1, 3'd5, 16'd0, 16'h1280, 1'b0, 1'b0, 1'b0);
    run_op("R3 upper cnt bits", 1, 1'b1, 1'b0, 3'd0, 16'h0023, 16'h8000, 1'b0, 1'b0, 1'b0);
    chk("R3 count 3 used", {16'd0, result}, 32'h1000);
  endtask

  task automatic t_busy();
    run_op("R13 start while busy", 0, 1'b1, 1'b1, 3'd4, 16'd0, 16'h0F0F, 1'b0, 1'b0, 1'b1);
    chk("R13 result unchanged", {16'd0, result}, 32'h0F0F_0 >> 4 << 4 & 32'hFFFF | 32'hF0F0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_lsl();
        t_right();
        t_rotate();
        t_zero();
        t_busy();
        finished = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
          n_run++;
          n_fail++;
          $display("FAIL watchdog R2 actual=hung expected=done");
        end
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule